// File: doc/BRIEF.md
# Multilevel-Table Complex-Gain Predistorter

This block predistorts a complex baseband sample stream ahead of a power amplifier. Each incoming I/Q sample is multiplied by a complex gain held in Cartesian form, which is the sum of one entry from each of seven parallel gain tables. The tables hold 1, 2, 4, 8, 16, 32 and 64 complex entries, 127 cells in all, and each table is addressed by the sample's amplitude scaled to that table's size. Small tables are touched by nearly every sample and pull the gain curve into shape quickly. The large tables refine it locally.

While adaptation is enabled, every selected cell in every table is nudged each cycle by a least-mean-square step. The step is formed from the conjugate of the input times the error between the input and a feedback sample that is already aligned in time. The per-table step is 1/32. An update whose magnitude falls below one cell LSB is lost, so very small errors stall the training. After reset the block passes samples through unchanged. A combinational read port exposes any cell by a flat address for inspection.

Top module: `mlg_predistorter`

## Requirements
- R1: After reset the single-entry table holds 1.0 (real 4096, imaginary 0) and every other cell holds 0+0j, so with adaptation off the output equals the input one cycle later.
- R2: The output is registered with one cycle of latency: y = x·g complex, each part scaled by floor(v/4096), where g is the gain before that cycle's update.
- R3: The gain g is the sum over all seven tables of the one selected cell in each table.
- R4: The amplitude is a = max(|I|,|Q|) + floor(min(|I|,|Q|)/2). Table k (2^k entries, k = 0..6) uses index min(floor(a/2^(13-k)), 2^k − 1), and its cell sits at flat address 2^k − 1 + index.
- R5: With adaptation enabled, the error is e = x − fb. Each selected cell gets conj(x)·e divided by 2^19 and truncated toward zero added to it, real and imaginary parts separately.
- R6: A step whose magnitude before truncation is below 2^19 leaves the cell unchanged. This holds for negative steps as well as positive ones.
- R7: While adaptation is disabled, no cell changes.
- R8: Each output part saturates to the range −8192..8191 and does not wrap.
- R9: A cell update saturates to the 16-bit cell range −32768..32767.
- R10: The read port returns the real and imaginary parts of the cell at the flat address combinationally. Address 127 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| adaptEn | input | 1 | Enables the per-cycle table update |
| xI | input | 14 | Input sample, real part (signed) |
| xQ | input | 14 | Input sample, imaginary part (signed) |
| fbI | input | 14 | Aligned feedback, real part (signed) |
| fbQ | input | 14 | Aligned feedback, imaginary part (signed) |
| rdAddr | input | 7 | Flat cell address for the read port |
| yI | output | 14 | Predistorted output, real part (signed) |
| yQ | output | 14 | Predistorted output, imaginary part (signed) |
| rdRe | output | 16 | Real part of the addressed cell (signed, 4096 = 1.0) |
| rdIm | output | 16 | Imaginary part of the addressed cell (signed) |

## Verification
The assertions check several properties on every cycle:
- The per-table indices stay nested, so each coarse index is the next finer index halved.
- The cells hold still when adaptation is off or when the error is exactly zero.
- The first sample after reset passes through unchanged.

Other behaviours only appear across scenarios:
- The exact LMS step value, which the bench tracks with its own model of all 127 cells.
- Truncation toward zero for small negative steps.
- Saturation of the outputs and of the cells.
- The amplitude-to-address mapping of individual samples, which the bench shows by reading back which cells moved.

// File: rtl/mlg_pkg.sv
package mlg_pkg;
  parameter int LVLS     = 7;
  parameter int DATA_W   = 14;
  parameter int CELL_W   = 16;
  parameter int FRAC     = 12;
  parameter int MU_SHIFT = 5;

  localparam int IDX_W     = LVLS - 1;
  localparam int CELLS     = (2 ** LVLS) - 1;
  localparam int ADDR_W    = LVLS;
  localparam int SUM_W     = CELL_W + $clog2(LVLS);
  localparam int ML_W      = DATA_W + SUM_W + 1;
  localparam int ERR_W     = DATA_W + 1;
  localparam int PROD_W    = 2 * DATA_W + 2;
  localparam int UPD_SHIFT = 2 * (DATA_W - 1) + MU_SHIFT - FRAC;
  localparam int DMAX      = (2 ** (DATA_W - 1)) - 1;
  localparam int DMIN      = -(2 ** (DATA_W - 1));
  localparam int CMAX      = (2 ** (CELL_W - 1)) - 1;
  localparam int CMIN      = -(2 ** (CELL_W - 1));

  typedef struct packed {
    logic                       updEn;
    logic [LVLS-1:0][IDX_W-1:0] idx;
  } lutStrobe_t;

  function automatic logic [ADDR_W-1:0] flatAddr(input int lvl, input logic [IDX_W-1:0] ix);
    return ADDR_W'((1 << lvl) - 1) + ADDR_W'(ix);
  endfunction

  // Step scaled to cell units, truncated toward zero (stalling below one LSB)
  function automatic logic signed [CELL_W:0] scaleStep(input logic signed [PROD_W-1:0] p);
    logic [PROD_W-1:0] mag;
    logic [PROD_W-1:0] sh;
    mag = p[PROD_W-1] ? PROD_W'(-p) : PROD_W'(p);
    sh  = mag >> UPD_SHIFT;
    return p[PROD_W-1] ? -$signed((CELL_W+1)'(sh)) : $signed((CELL_W+1)'(sh));
  endfunction

  function automatic logic signed [CELL_W-1:0] satCell(input logic signed [CELL_W+1:0] v);
    if (v > (CELL_W+2)'(CMAX)) return CELL_W'(CMAX);
    if (v < (CELL_W+2)'(CMIN)) return CELL_W'(CMIN);
    return v[CELL_W-1:0];
  endfunction

  function automatic logic signed [DATA_W-1:0] satData(input logic signed [ML_W-1:0] v);
    if (v > ML_W'(DMAX)) return DATA_W'(DMAX);
    if (v < ML_W'(DMIN)) return DATA_W'(DMIN);
    return v[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/mlg_ctrl.sv
module mlg_ctrl
  import mlg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adaptEn,
  input  logic signed [DATA_W-1:0] xI,
  input  logic signed [DATA_W-1:0] xQ,
  output lutStrobe_t               stb
);
  logic [DATA_W-1:0] magI, magQ, bigMag, smallMag;
  logic [DATA_W:0]   amp;

  always_comb begin
    magI     = xI[DATA_W-1] ? DATA_W'(-xI) : DATA_W'(xI);
    magQ     = xQ[DATA_W-1] ? DATA_W'(-xQ) : DATA_W'(xQ);
    bigMag   = (magI >= magQ) ? magI : magQ;
    smallMag = (magI >= magQ) ? magQ : magI;
    amp      = {1'b0, bigMag} + {2'b00, smallMag[DATA_W-1:1]};
  end

  assign stb.updEn = adaptEn;

  for (genvar k = 0; k < LVLS; k++) begin : g_lvl
    localparam int SH = DATA_W - 1 - k;
    logic [DATA_W:0] scaled;
    assign scaled = amp >> SH;
    assign stb.idx[k] = (scaled > (DATA_W+1)'((1 << k) - 1)) ? IDX_W'((1 << k) - 1)
                                                             : IDX_W'(scaled);
    if (k > 0) begin : g_nest
      // coarse index equals finer index halved
      p_nested_idx_r4: assert property (@(posedge clk) disable iff (rst)
        (stb.idx[k] >> 1) == stb.idx[k-1]);
    end
  end
endmodule

// File: rtl/mlg_datapath.sv
module mlg_datapath
  import mlg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  lutStrobe_t               stb,
  input  logic signed [DATA_W-1:0] xI,
  input  logic signed [DATA_W-1:0] xQ,
  input  logic signed [DATA_W-1:0] fbI,
  input  logic signed [DATA_W-1:0] fbQ,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic signed [DATA_W-1:0] yI,
  output logic signed [DATA_W-1:0] yQ,
  output logic signed [CELL_W-1:0] rdRe,
  output logic signed [CELL_W-1:0] rdIm
);
  logic signed [CELL_W-1:0] cellRe [CELLS];
  logic signed [CELL_W-1:0] cellIm [CELLS];
  logic [ADDR_W-1:0]        sel    [LVLS];
  logic signed [CELL_W-1:0] newRe  [LVLS];
  logic signed [CELL_W-1:0] newIm  [LVLS];
  logic signed [SUM_W-1:0]  gRe, gIm;
  logic signed [ML_W-1:0]   mRe, mIm;
  logic signed [ERR_W-1:0]  eI, eQ;
  logic signed [PROD_W-1:0] pRe, pIm;
  logic signed [CELL_W:0]   dRe, dIm;

  // gain: one cell per table, summed
  always_comb begin
    gRe = '0;
    gIm = '0;
    for (int k = 0; k < LVLS; k++) begin
      sel[k] = flatAddr(k, stb.idx[k]);
      gRe    = gRe + SUM_W'(cellRe[sel[k]]);
      gIm    = gIm + SUM_W'(cellIm[sel[k]]);
    end
    mRe = ML_W'(xI) * ML_W'(gRe) - ML_W'(xQ) * ML_W'(gIm);
    mIm = ML_W'(xI) * ML_W'(gIm) + ML_W'(xQ) * ML_W'(gRe);
  end

  // LMS step: conj(x) * (x - fb)
  always_comb begin
    eI  = ERR_W'(xI) - ERR_W'(fbI);
    eQ  = ERR_W'(xQ) - ERR_W'(fbQ);
    pRe = PROD_W'(xI) * PROD_W'(eI) + PROD_W'(xQ) * PROD_W'(eQ);
    pIm = PROD_W'(xI) * PROD_W'(eQ) - PROD_W'(xQ) * PROD_W'(eI);
    dRe = scaleStep(pRe);
    dIm = scaleStep(pIm);
    for (int k = 0; k < LVLS; k++) begin
      newRe[k] = satCell((CELL_W+2)'(cellRe[sel[k]]) + (CELL_W+2)'(dRe));
      newIm[k] = satCell((CELL_W+2)'(cellIm[sel[k]]) + (CELL_W+2)'(dIm));
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      yI <= '0;
      yQ <= '0;
      for (int c = 0; c < CELLS; c++) begin
        cellRe[c] <= (c == 0) ? CELL_W'(1 << FRAC) : '0;
        cellIm[c] <= '0;
      end
    end else begin
      yI <= satData(mRe >>> FRAC);
      yQ <= satData(mIm >>> FRAC);
      if (stb.updEn) begin
        for (int k = 0; k < LVLS; k++) begin
          cellRe[sel[k]] <= newRe[k];
          cellIm[sel[k]] <= newIm[k];
        end
      end
    end
  end

  assign rdRe = (int'(rdAddr) < CELLS) ? cellRe[rdAddr] : '0;
  assign rdIm = (int'(rdAddr) < CELLS) ? cellIm[rdAddr] : '0;

  p_hold_no_adapt_r7: assert property (@(posedge clk) disable iff (rst)
    !stb.updEn |=> (rdAddr != $past(rdAddr)) || ($stable(rdRe) && $stable(rdIm)));

  p_zero_err_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (stb.updEn && xI == fbI && xQ == fbQ) |=>
      (rdAddr != $past(rdAddr)) || ($stable(rdRe) && $stable(rdIm)));

  p_transparent_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> (yI == $past(xI)) && (yQ == $past(xQ)));
endmodule

// File: rtl/mlg_predistorter.sv
module mlg_predistorter
  import mlg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adaptEn,
  input  logic signed [DATA_W-1:0] xI,
  input  logic signed [DATA_W-1:0] xQ,
  input  logic signed [DATA_W-1:0] fbI,
  input  logic signed [DATA_W-1:0] fbQ,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic signed [DATA_W-1:0] yI,
  output logic signed [DATA_W-1:0] yQ,
  output logic signed [CELL_W-1:0] rdRe,
  output logic signed [CELL_W-1:0] rdIm
);
  lutStrobe_t stb;

  mlg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .adaptEn(adaptEn), .xI(xI), .xQ(xQ), .stb(stb)
  );

  mlg_datapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .xI(xI), .xQ(xQ), .fbI(fbI), .fbQ(fbQ),
    .rdAddr(rdAddr), .yI(yI), .yQ(yQ), .rdRe(rdRe), .rdIm(rdIm)
  );
endmodule

// File: tb/mlg_predistorter_tb.sv
module mlg_predistorter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adaptEn = 1'b0;
  logic signed [13:0] xI = '0, xQ = '0, fbI = '0, fbQ = '0;
  logic [6:0] rdAddr = '0;
  logic signed [13:0] yI, yQ;
  logic signed [15:0] rdRe, rdIm;

  int nVec = 0, nBad = 0;
  int mRe [127];
  int mIm [127];
  bit done = 0;

  always #2 clk = ~clk;  // 4-unit period, 250 MHz nominal

  mlg_predistorter u_dut (
    .clk(clk), .rst(rst), .adaptEn(adaptEn), .xI(xI), .xQ(xQ), .fbI(fbI), .fbQ(fbQ),
    .rdAddr(rdAddr), .yI(yI), .yQ(yQ), .rdRe(rdRe), .rdIm(rdIm)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic longint clampL(input longint v, input longint lo, input longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  // R4: amplitude and per-table flat address
  function automatic int cellOf(input int i, input int q, input int k);
    int a, hi, lo, ix;
    hi = (iabs(i) > iabs(q)) ? iabs(i) : iabs(q);
    lo = (iabs(i) > iabs(q)) ? iabs(q) : iabs(i);
    a  = hi + lo / 2;
    ix = a / (1 << (13 - k));
    if (ix > (1 << k) - 1) ix = (1 << k) - 1;
    return (1 << k) - 1 + ix;
  endfunction

  task automatic modelReset();
    for (int c = 0; c < 127; c++) begin
      mRe[c] = (c == 0) ? 4096 : 0;
      mIm[c] = 0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    adaptEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  // one sample: check R2/R3/R8 output, then R5/R6/R9 model update
  task automatic step(input int i, input int q, input int fi, input int fq, input bit en, input string tag);
    longint gr, gi, er, ei, pr, pi, eyI, eyQ;
    int c;
    @(negedge clk);
    xI = 14'(i); xQ = 14'(q); fbI = 14'(fi); fbQ = 14'(fq); adaptEn = en;
    gr = 0; gi = 0;
    for (int k = 0; k < 7; k++) begin
      c = cellOf(i, q, k);
      gr += mRe[c];
      gi += mIm[c];
    end
    eyI = clampL((longint'(i) * gr - longint'(q) * gi) >>> 12, -8192, 8191);
    eyQ = clampL((longint'(i) * gi + longint'(q) * gr) >>> 12, -8192, 8191);
    if (en) begin
      er = i - fi; ei = q - fq;
      pr = (i * er + q * ei) / 524288;
      pi = (i * ei - q * er) / 524288;
      for (int k = 0; k < 7; k++) begin
        c = cellOf(i, q, k);
        mRe[c] = int'(clampL(mRe[c] + pr, -32768, 32767));
        mIm[c] = int'(clampL(mIm[c] + pi, -32768, 32767));
      end
    end
    @(posedge clk);
    #1;
    chk({tag, " yI"}, yI, eyI);
    chk({tag, " yQ"}, yQ, eyQ);
  endtask

  // R10: full table readback against the model (adaptation off)
  task automatic dump(input string tag);
    @(negedge clk);
    adaptEn = 1'b0;
    for (int a = 0; a < 128; a++) begin
      rdAddr = 7'(a);
      #1;
      chk({tag, " re"}, rdRe, (a < 127) ? mRe[a] : 0);
      chk({tag, " im"}, rdIm, (a < 127) ? mIm[a] : 0);
    end
  endtask

  task automatic readCell(input int a, output int re, output int im);
    rdAddr = 7'(a);
    #1;
    re = rdRe;
    im = rdIm;
  endtask

  initial begin
    int re, im;
    logic [31:0] lfsr;
    modelReset();
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1, R10: reset contents
    dump("R1 R10 reset table");

    // R1, R2, R7: transparent sweep, adaptation off
    for (int a = -8192; a <= 8191; a += 1024)
      for (int b = -8192; b <= 8191; b += 1024)
        step(a, b, a / 2, -b, 1'b0, "R1 R2 transparent");
    step(8191, -8192, 0, 0, 1'b0, "R1 R8 extreme");
    dump("R7 unchanged after sweep");

    // R4, R5: single update lands at the expected cells
    step(4096, 2048, 0, 0, 1'b1, "R5 single update");
    @(negedge clk);
    adaptEn = 1'b0;
    readCell(103, re, im);
    chk("R4 R5 level6 cell 103", re, 40);
    readCell(2, re, im);
    chk("R4 R5 level1 cell 2", re, 40);
    readCell(0, re, im);
    chk("R5 level0 cell", re, 4096 + 40);
    dump("R4 R5 after single update");

    // R2, R3, R5: pseudo-random adaptation against the model
    doReset();
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 3000; n++) begin
      int i, q, fi, fq;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      i = int'($signed(lfsr[13:0]));
      q = int'($signed(lfsr[27:14]));
      fi = int'(clampL(lfsr[28] ? i + i / 8 : i - i / 8, -8192, 8191));
      fq = int'(clampL(lfsr[29] ? q - q / 8 : q + q / 8, -8192, 8191));
      step(i, q, fi, fq, lfsr[30] | lfsr[31], "R2 R3 R5 random");
    end
    dump("R3 R5 table after random");

    // R6: stalling for positive and negative sub-LSB steps
    doReset();
    for (int n = 0; n < 6; n++) step(100, 0, 50, 0, 1'b1, "R6 stall pos");
    for (int n = 0; n < 6; n++) step(100, 0, 150, 0, 1'b1, "R6 stall neg");
    for (int n = 0; n < 6; n++) step(0, -300, 0, -290, 1'b1, "R6 stall neg q");
    @(negedge clk);
    adaptEn = 1'b0;
    readCell(0, re, im);
    chk("R6 level0 unchanged", re, 4096);
    chk("R6 level0 imag unchanged", im, 0);
    dump("R6 table after stall");

    // R8, R9: gain growth to output and cell saturation
    doReset();
    for (int n = 0; n < 160; n++) step(8191, 8191, 0, 0, 1'b1, "R8 R9 growth");
    chk("R8 yI positive clip", yI, 8191);
    chk("R8 yQ positive clip", yQ, 8191);
    step(-8192, -8192, 0, 0, 1'b0, "R8 negative");
    chk("R8 yI negative clip", yI, -8192);
    chk("R8 yQ negative clip", yQ, -8192);
    @(negedge clk);
    readCell(126, re, im);
    chk("R9 cell 126 clipped", re, 32767);
    readCell(0, re, im);
    chk("R9 cell 0 clipped", re, 32767);
    dump("R9 table after growth");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule